// File: doc/BRIEF.md
# Mailbox Boot Upload Sequencer

This block runs the host side of a boot handshake across a four-byte mailbox shared with a small remote processor. After a start command it waits for the remote side to show its ready signature, sends a command byte, and then programs an address and a mode word. In direct mode it only hands over a launch address and waits for the acknowledge. In upload mode it first hands over the load address, then streams a counted number of bytes and tags each one with an index. Each byte waits until the remote side echoes its index. At the end it hands over the launch address with a zero mode word.

Bytes to upload enter on a valid/ready stream. `s_ready` is high only while the sequencer waits for the next byte, and it does not depend on `s_valid`. A byte is taken on a clock edge where both signals are high. After a transfer, `s_ready` stays low until the remote side has echoed that byte's index. A source may hold `s_valid` low for as long as it likes. The remote side paces the upload, so the stream only ever sees back-pressure. Command fields are sampled on the cycle `cmd_start` is high in the idle state. Only inbound bytes 0 and 1 carry anything the host reads.

Top module: `mbox_boot_seq`

## Requirements
- R1: After reset all four outbound bytes read 0x00, and `busy`, `done` and `s_ready` are low.
- R2: `cmd_start` is accepted only while `busy` is low. `busy` rises the cycle after acceptance and stays high until the cycle `done` pulses. A start while busy has no effect on the running sequence.
- R3: Outbound byte 0 is not written until inbound byte 0 reads 0xAA and inbound byte 1 reads 0xBB in the same cycle. The cycle after that, outbound byte 0 becomes 0xCC.
- R4: The cycle after 0xCC, outbound byte 2 takes the address low byte and outbound byte 3 takes the high byte. This is `cmd_load_addr` in upload mode and `cmd_entry` in direct mode.
- R5: The next cycle writes the mode word in a single cycle: outbound byte 0 gets 0x00, and outbound byte 1 gets 0x01 for upload or 0x00 for direct.
- R6: After a mode word, the sequencer waits until inbound byte 0 reads 0x00. For a zero mode word it then pulses `done` and returns to idle.
- R7: The first upload index is `cmd_first_idx`. A value of 0 is replaced by 1.
- R8: Each accepted byte appears on outbound byte 1 in the same cycle that its index appears on outbound byte 0. The next byte is not accepted until inbound byte 0 equals that index.
- R9: The index rises by one per echoed byte and wraps from 0xFF to 0x00.
- R10: After `cmd_count` echoed bytes, or straight after the upload acknowledge when `cmd_count` is 0, `cmd_entry` is written to outbound bytes 2 and 3, followed by a 0x00/0x00 mode word. The R6 wait then applies.
- R11: `done` lasts exactly one cycle, and `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start request, sampled in idle |
| cmd_upload | input | 1 | 1 selects upload, 0 selects direct launch |
| cmd_first_idx | input | 8 | First transfer index (0 treated as 1) |
| cmd_count | input | CNT_W | Number of bytes to upload |
| cmd_load_addr | input | 16 | Load address handed over before upload |
| cmd_entry | input | 16 | Launch address |
| rx_p0 | input | 8 | Inbound mailbox byte 0 (signature low, echo) |
| rx_p1 | input | 8 | Inbound mailbox byte 1 (signature high) |
| tx_p0 | output | 8 | Outbound mailbox byte 0 (command, mode low, index) |
| tx_p1 | output | 8 | Outbound mailbox byte 1 (mode high, data) |
| tx_p2 | output | 8 | Outbound mailbox byte 2 (address low) |
| tx_p3 | output | 8 | Outbound mailbox byte 3 (address high) |
| s_valid | input | 1 | Upload byte valid |
| s_data | input | 8 | Upload byte |
| s_ready | output | 1 | Sequencer can take an upload byte |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bound assertions check properties that hold on every cycle. Outbound byte 0 never changes before the signature has been seen. A taken byte lands on outbound byte 1 on the next cycle. Only one byte is in flight at a time. `s_ready` implies `busy`. The address bytes stay put while idle. `done` is a single-cycle pulse that follows a zero echo. Other behaviours only show up across whole bench scenarios: the exact order of written mailbox values, the zero-to-one fix on the first index, the index wrap across 0xFF, the empty upload, and the ignored mid-run start. The bench shows these by playing the remote side with different echo delays and comparing against its reference model.

// File: rtl/mbox_boot_pkg.sv
package mbox_boot_pkg;

  localparam int NPORT = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SIG,
    ST_ADDR,
    ST_MODE,
    ST_ACK,
    ST_FEED,
    ST_ECHO
  } seq_state_e;

  typedef struct packed {
    logic [NPORT-1:0]      we;
    logic [NPORT-1:0][7:0] wd;
  } port_wr_t;

endpackage

// File: rtl/mbox_xfer_ctr.sv
module mbox_xfer_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       first_idx,
  input  logic [CNT_W-1:0] count,
  input  logic             step,
  output logic [7:0]       idx,
  output logic             rem_last,
  output logic             rem_zero
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] rem_q;
  logic [7:0]       idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      rem_q <= '0;
    end else if (load) begin
      idx_q <= (first_idx == 8'h00) ? 8'h01 : first_idx;
      rem_q <= count;
    end else if (step) begin
      idx_q <= idx_q + 8'h01;
      rem_q <= rem_q - ONE;
    end
  end

  assign idx      = idx_q;
  assign rem_last = (rem_q == ONE);
  assign rem_zero = (rem_q == '0);

endmodule

// File: rtl/mbox_tx_bank.sv
module mbox_tx_bank
  import mbox_boot_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  port_wr_t              wr,
  output logic [NPORT-1:0][7:0] q
);

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[i] <= 8'h00;
      else if (wr.we[i]) q[i] <= wr.wd[i];
    end
  end

endmodule

// File: rtl/mbox_boot_fsm.sv
module mbox_boot_fsm
  import mbox_boot_pkg::*;
#(
  parameter logic [7:0] SIG_LO      = 8'hAA,
  parameter logic [7:0] SIG_HI      = 8'hBB,
  parameter logic [7:0] KICK_CODE   = 8'hCC,
  parameter logic [7:0] UPLOAD_MODE = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_start,
  input  logic        cmd_upload,
  input  logic [15:0] cmd_load_addr,
  input  logic [15:0] cmd_entry,
  input  logic [7:0]  rx_p0,
  input  logic [7:0]  rx_p1,
  input  logic        s_valid,
  input  logic [7:0]  s_data,
  input  logic [7:0]  idx,
  input  logic        rem_last,
  input  logic        rem_zero,
  output port_wr_t    wr,
  output logic        ctr_load,
  output logic        ctr_step,
  output logic        s_ready,
  output logic        busy,
  output logic        done
);

  seq_state_e state_q, state_d;
  logic        up_q, launch_q, launch_d;
  logic [15:0] load_q, entry_q;
  logic        busy_q, done_q, done_d;
  logic        setup;
  logic        sig_ok, zero_ack, echo_hit;
  logic [15:0] addr_sel;

  assign setup    = up_q && !launch_q;
  assign sig_ok   = (rx_p0 == SIG_LO) && (rx_p1 == SIG_HI);
  assign zero_ack = (rx_p0 == 8'h00);
  assign echo_hit = (rx_p0 == idx);
  assign addr_sel = setup ? load_q : entry_q;

  always_comb begin
    state_d  = state_q;
    launch_d = launch_q;
    done_d   = 1'b0;
    wr       = '0;
    ctr_load = 1'b0;
    ctr_step = 1'b0;
    s_ready  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_start) begin
          ctr_load = 1'b1;
          launch_d = 1'b0;
          state_d  = ST_SIG;
        end
      end
      ST_SIG: begin
        if (sig_ok) begin
          wr.we[0] = 1'b1;
          wr.wd[0] = KICK_CODE;
          state_d  = ST_ADDR;
        end
      end
      ST_ADDR: begin
        wr.we[2] = 1'b1;
        wr.wd[2] = addr_sel[7:0];
        wr.we[3] = 1'b1;
        wr.wd[3] = addr_sel[15:8];
        state_d  = ST_MODE;
      end
      ST_MODE: begin
        wr.we[0] = 1'b1;
        wr.wd[0] = 8'h00;
        wr.we[1] = 1'b1;
        wr.wd[1] = setup ? UPLOAD_MODE : 8'h00;
        state_d  = ST_ACK;
      end
      ST_ACK: begin
        if (zero_ack) begin
          if (setup) begin
            if (rem_zero) begin
              launch_d = 1'b1;
              state_d  = ST_ADDR;
            end else begin
              state_d  = ST_FEED;
            end
          end else begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_FEED: begin
        s_ready = 1'b1;
        if (s_valid) begin
          wr.we[0] = 1'b1;
          wr.wd[0] = idx;
          wr.we[1] = 1'b1;
          wr.wd[1] = s_data;
          state_d  = ST_ECHO;
        end
      end
      ST_ECHO: begin
        if (echo_hit) begin
          ctr_step = 1'b1;
          if (rem_last) begin
            launch_d = 1'b1;
            state_d  = ST_ADDR;
          end else begin
            state_d  = ST_FEED;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      launch_q <= 1'b0;
      up_q     <= 1'b0;
      load_q   <= 16'h0000;
      entry_q  <= 16'h0000;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q  <= state_d;
      launch_q <= launch_d;
      done_q   <= done_d;
      if (ctr_load) begin
        up_q    <= cmd_upload;
        load_q  <= cmd_load_addr;
        entry_q <= cmd_entry;
        busy_q  <= 1'b1;
      end else if (done_d) begin
        busy_q  <= 1'b0;
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;

endmodule

// File: rtl/mbox_boot_seq.sv
module mbox_boot_seq
  import mbox_boot_pkg::*;
#(
  parameter int         CNT_W       = 16,
  parameter logic [7:0] SIG_LO      = 8'hAA,
  parameter logic [7:0] SIG_HI      = 8'hBB,
  parameter logic [7:0] KICK_CODE   = 8'hCC,
  parameter logic [7:0] UPLOAD_MODE = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_start,
  input  logic             cmd_upload,
  input  logic [7:0]       cmd_first_idx,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic [15:0]      cmd_load_addr,
  input  logic [15:0]      cmd_entry,
  input  logic [7:0]       rx_p0,
  input  logic [7:0]       rx_p1,
  output logic [7:0]       tx_p0,
  output logic [7:0]       tx_p1,
  output logic [7:0]       tx_p2,
  output logic [7:0]       tx_p3,
  input  logic             s_valid,
  input  logic [7:0]       s_data,
  output logic             s_ready,
  output logic             busy,
  output logic             done
);

  port_wr_t              wr;
  logic [NPORT-1:0][7:0] port_q;
  logic                  ctr_load, ctr_step;
  logic [7:0]            idx;
  logic                  rem_last, rem_zero;

  mbox_boot_fsm #(
    .SIG_LO      (SIG_LO),
    .SIG_HI      (SIG_HI),
    .KICK_CODE   (KICK_CODE),
    .UPLOAD_MODE (UPLOAD_MODE)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_start     (cmd_start),
    .cmd_upload    (cmd_upload),
    .cmd_load_addr (cmd_load_addr),
    .cmd_entry     (cmd_entry),
    .rx_p0         (rx_p0),
    .rx_p1         (rx_p1),
    .s_valid       (s_valid),
    .s_data        (s_data),
    .idx           (idx),
    .rem_last      (rem_last),
    .rem_zero      (rem_zero),
    .wr            (wr),
    .ctr_load      (ctr_load),
    .ctr_step      (ctr_step),
    .s_ready       (s_ready),
    .busy          (busy),
    .done          (done)
  );

  mbox_xfer_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ctr_load),
    .first_idx (cmd_first_idx),
    .count     (cmd_count),
    .step      (ctr_step),
    .idx       (idx),
    .rem_last  (rem_last),
    .rem_zero  (rem_zero)
  );

  mbox_tx_bank u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (wr),
    .q     (port_q)
  );

  assign tx_p0 = port_q[0];
  assign tx_p1 = port_q[1];
  assign tx_p2 = port_q[2];
  assign tx_p3 = port_q[3];

endmodule

// File: rtl/mbox_boot_chk.sv
module mbox_boot_chk #(
  parameter logic [7:0] SIG_LO = 8'hAA,
  parameter logic [7:0] SIG_HI = 8'hBB
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rx_p0,
  input logic [7:0] rx_p1,
  input logic [7:0] tx_p0,
  input logic [7:0] tx_p1,
  input logic [7:0] tx_p2,
  input logic [7:0] tx_p3,
  input logic       s_valid,
  input logic [7:0] s_data,
  input logic       s_ready,
  input logic       busy,
  input logic       done
);

  // Tracks whether the signature was seen during the current run.
  logic sig_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               sig_seen <= 1'b0;
    else if (!busy)                           sig_seen <= 1'b0;
    else if (rx_p0 == SIG_LO && rx_p1 == SIG_HI) sig_seen <= 1'b1;
  end

  p_kick_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_p0 != $past(tx_p0)) |-> $past(sig_seen || (rx_p0 == SIG_LO && rx_p1 == SIG_HI)));

  p_addr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> ($stable(tx_p2) && $stable(tx_p3)));

  p_launch_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rx_p0 == 8'h00));

  p_data_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (tx_p1 == $past(s_data)));

  p_one_in_flight_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  p_ready_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_ends_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

endmodule

bind mbox_boot_seq mbox_boot_chk #(.SIG_LO(SIG_LO), .SIG_HI(SIG_HI)) u_chk (.*);

// File: tb/tb_mbox_boot_seq.sv
module tb_mbox_boot_seq;

  localparam int CNT_W = 16;
  localparam logic [7:0] SIG_LO = 8'hAA, SIG_HI = 8'hBB, KICK = 8'hCC;
  localparam int M_IDLE = 0, M_SIG = 1, M_ADDR = 2, M_MODE = 3, M_ACK = 4, M_FEED = 5, M_ECHO = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0, cmd_upload = 1'b0;
  logic [7:0] cmd_first_idx = 8'h00;
  logic [CNT_W-1:0] cmd_count = '0;
  logic [15:0] cmd_load_addr = 16'h0, cmd_entry = 16'h0;
  logic [7:0] rx_p0 = 8'h00, rx_p1 = 8'h00;
  logic [7:0] tx_p0, tx_p1, tx_p2, tx_p3;
  logic s_valid = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, busy, done;

  always #5 clk = ~clk;

  mbox_boot_seq #(.CNT_W(CNT_W)) dut (.*);

  int vectors = 0, fails = 0, cyc = 0;

  // Remote-side responder state
  bit sig_lo = 0, sig_hi = 0, armed = 0;
  int lag = 2;
  logic [7:0] hist [8];

  // Stream source
  logic [7:0] src_q[$];
  bit pend_take = 0;
  int gap_ctr = 0;

  // Captured (index,data) pairs whenever outbound byte 0 changes
  logic [15:0] pair_q[$];
  logic [7:0] prev_tx0 = 8'h00;

  // Reference model
  int ms = M_IDLE;
  logic [7:0] m_tx [4];
  bit m_busy = 0, m_done = 0, m_up = 0, m_launch = 0;
  logic [15:0] m_load, m_entry;
  int m_idx = 0, m_rem = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    m_done = 0;
    if (!rst_n) begin
      ms = M_IDLE; m_busy = 0; m_up = 0; m_launch = 0;
      for (int k = 0; k < 4; k++) m_tx[k] = 8'h00;
    end else begin
      case (ms)
        M_IDLE: if (cmd_start) begin
          m_up = cmd_upload; m_load = cmd_load_addr; m_entry = cmd_entry;
          m_idx = (cmd_first_idx == 0) ? 1 : int'(cmd_first_idx);
          m_rem = int'(cmd_count); m_launch = 0; m_busy = 1; ms = M_SIG;
        end
        M_SIG: if (rx_p0 == SIG_LO && rx_p1 == SIG_HI) begin m_tx[0] = KICK; ms = M_ADDR; end
        M_ADDR: begin
          if (m_up && !m_launch) begin m_tx[2] = m_load[7:0]; m_tx[3] = m_load[15:8]; end
          else begin m_tx[2] = m_entry[7:0]; m_tx[3] = m_entry[15:8]; end
          ms = M_MODE;
        end
        M_MODE: begin
          m_tx[0] = 8'h00; m_tx[1] = (m_up && !m_launch) ? 8'h01 : 8'h00; ms = M_ACK;
        end
        M_ACK: if (rx_p0 == 8'h00) begin
          if (m_up && !m_launch) begin
            if (m_rem == 0) begin m_launch = 1; ms = M_ADDR; end else ms = M_FEED;
          end else begin m_done = 1; m_busy = 0; ms = M_IDLE; end
        end
        M_FEED: if (s_valid) begin m_tx[1] = s_data; m_tx[0] = 8'(m_idx); ms = M_ECHO; end
        M_ECHO: if (rx_p0 == 8'(m_idx)) begin
          m_idx = (m_idx + 1) % 256; m_rem--;
          if (m_rem == 0) begin m_launch = 1; ms = M_ADDR; end else ms = M_FEED;
        end
        default: ms = M_IDLE;
      endcase
    end
  end

  // Per-cycle compare, responder and stream driver, all at the falling edge
  initial begin
    for (int k = 0; k < 8; k++) hist[k] = 8'h00;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 150000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
      end
      if (rst_n) begin
        chk(tx_p0 == m_tx[0], "R3 tx_p0", tx_p0, m_tx[0]);
        chk(tx_p1 == m_tx[1], "R8 tx_p1", tx_p1, m_tx[1]);
        chk(tx_p2 == m_tx[2] && tx_p3 == m_tx[3], "R4 tx_p3:p2", {tx_p3, tx_p2}, {m_tx[3], m_tx[2]});
        chk(busy == m_busy, "R2 busy", busy, m_busy);
        chk(done == m_done, "R11 done", done, m_done);
        chk(s_ready == (ms == M_FEED), "R8 s_ready", s_ready, ms == M_FEED);
      end
      if (tx_p0 != prev_tx0) pair_q.push_back({tx_p0, tx_p1});
      prev_tx0 = tx_p0;
      for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = tx_p0;
      if (!armed && tx_p0 == KICK) begin
        armed = 1;
        for (int k = 0; k < 8; k++) hist[k] = KICK;
      end
      rx_p0 = armed ? hist[lag] : (sig_lo ? SIG_LO : 8'h00);
      rx_p1 = sig_hi ? SIG_HI : 8'h00;
      if (pend_take) void'(src_q.pop_front());
      if (!(s_valid && !pend_take)) begin
        gap_ctr++;
        s_valid = (src_q.size() > 0) && (gap_ctr % 3 != 0);
        s_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
      end
      pend_take = s_valid && s_ready;
    end
  end

  task automatic run_case(input bit up, input logic [7:0] first, input int cnt,
                          input logic [15:0] load, input logic [15:0] entry,
                          input int l, input bit poke);
    logic [7:0] sent[$];
    int n;
    int exp_idx;
    bit seen_done;
    @(negedge clk);
    armed = 0; sig_lo = 0; sig_hi = 0; lag = l;
    pair_q.delete();
    for (int k = 0; k < cnt; k++) begin
      src_q.push_back(8'((k * 37 + 11) ^ cnt));
      sent.push_back(8'((k * 37 + 11) ^ cnt));
    end
    cmd_upload = up; cmd_first_idx = first; cmd_count = CNT_W'(cnt);
    cmd_load_addr = load; cmd_entry = entry; cmd_start = 1;
    @(negedge clk);
    cmd_start = 0;
    repeat (3) @(negedge clk);
    sig_lo = 1;
    repeat (8) @(negedge clk);
    chk(tx_p0 != KICK, "R3 partial signature", tx_p0, 0);
    sig_hi = 1;
    seen_done = 0;
    n = 0;
    while (!seen_done && n < 20000) begin
      @(negedge clk);
      n++;
      if (poke && n == 40) begin
        cmd_start = 1; cmd_upload = 0; cmd_entry = 16'hDEAD; cmd_count = '0;
      end else cmd_start = 0;
      if (done) seen_done = 1;
    end
    chk(seen_done, "R6 done reached", seen_done, 1);
    chk({tx_p3, tx_p2} == entry, "R10 launch address", {tx_p3, tx_p2}, entry);
    chk(tx_p0 == 8'h00 && tx_p1 == 8'h00, "R10 zero mode word", {tx_p1, tx_p0}, 0);
    @(negedge clk);
    chk(!busy && !done, "R11 idle after done", {busy, done}, 0);
    if (up && cnt > 0) begin
      chk(pair_q.size() == cnt + 3, "R8 write count", pair_q.size(), cnt + 3);
      chk(pair_q.size() > 1 && pair_q[1] == 16'h0001, "R5 upload mode word", pair_q[1], 16'h0001);
      exp_idx = (first == 0) ? 1 : int'(first);
      chk(pair_q.size() > 2 && pair_q[2][15:8] == 8'(exp_idx), "R7 first index", pair_q[2][15:8], exp_idx);
      for (int k = 0; k < cnt && k + 2 < pair_q.size(); k++) begin
        chk(pair_q[k+2][15:8] == 8'((exp_idx + k) % 256), "R9 index sequence",
            pair_q[k+2][15:8], (exp_idx + k) % 256);
        chk(pair_q[k+2][7:0] == sent[k], "R8 data byte", pair_q[k+2][7:0], sent[k]);
      end
    end
    if (!up) begin
      chk(pair_q.size() == 2 && pair_q[0][15:8] == KICK, "R5 direct sequence", pair_q.size(), 2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_p0 == 0 && tx_p1 == 0 && tx_p2 == 0 && tx_p3 == 0, "R1 ports reset",
        {tx_p3, tx_p2, tx_p1, tx_p0}, 0);
    chk(!busy && !done && !s_ready, "R1 flags reset", {busy, done, s_ready}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_case(0, 8'h00, 0, 16'h0000, 16'h1234, 3, 0);
    run_case(1, 8'h00, 6, 16'h0200, 16'h0400, 2, 0);
    run_case(1, 8'hFE, 5, 16'h0300, 16'h0500, 5, 1);
    run_case(1, 8'h10, 0, 16'h0600, 16'h0700, 1, 0);
    run_case(1, 8'h01, 300, 16'h1000, 16'h2000, 1, 0);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule